// File: doc/BRIEF.md
# Phase-Accumulator LED Blink Divider

This block turns a fast system clock into a slow square wave suitable for driving a visible indicator lamp. Instead of counting up to a terminal value and clearing, it keeps an N-bit phase register that gains a fixed step on every clock and simply rolls over when it passes the top of its range. The most significant bit of that register is the output. The output frequency is therefore clock × STEP / 2^N. With the default 32-bit width and a step of 215, a 48 MHz clock gives a blink rate of about 2.403 Hz.

Because the step need not divide 2^N, individual output periods alternate between the two integers on either side of 2^N/STEP. Their long-run average matches 2^N/STEP exactly. A synchronous active-high reset returns the phase to zero.

Top module: `led_blink_div`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase register becomes zero and `led_o` is low after that edge.
- R2: At every rising edge with `rst` low, the phase register gains exactly STEP, modulo 2^ACC_W. After k such edges following reset, the phase equals (k·STEP) mod 2^ACC_W.
- R3: `led_o` is 1 exactly when the phase register is at or above 2^(ACC_W−1). It changes only at rising clock edges, because it comes directly from a flop.
- R4: The phase rolls over past 2^ACC_W with no saturation and no terminal compare. On a falling output edge, the new phase is below STEP.
- R5: The number of clock cycles between two successive rising edges of `led_o` is always floor(2^ACC_W/STEP) or ceil(2^ACC_W/STEP).
- R6: Over many periods, the mean cycle count between rising edges of `led_o` is within one cycle of 2^ACC_W/STEP.
- R7: A reset applied in the middle of a run restarts the sequence from phase zero. The output stays low for the first ceil(2^(ACC_W−1)/STEP)−1 cycles after release.
- R8: STEP must be nonzero and below 2^(ACC_W−1). Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the phase advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the phase |
| led_o | output | 1 | Blink drive; top bit of the registered phase |

## Verification
A corrupted phase register shows at the port as a shifted output edge. A wrong step shows as a drifting rising-edge spacing. The per-cycle comparison against (k·STEP) mod 2^N catches either one within about one output period, which is tens of cycles in the reduced configurations. A bad rollover, such as saturation or an early clear, makes one period leave the floor/ceil pair at the very next rising edge. A reset that fails to clear shows as an output that is not low on the first cycle after reset.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    // Legal step: nonzero and strictly below half the phase range.
    function automatic bit step_is_legal(input int unsigned width,
                                         input longint unsigned step);
        longint unsigned half;
        half = 64'd1 << (width - 1);
        return (step != 0) && (step < half) && (width >= 2) && (width <= 62);
    endfunction

endpackage

// File: rtl/phacc_step.sv
// Combinational phase increment; rolls over naturally at the register width.
module phacc_step #(
    parameter int unsigned      ACC_W = 32,
    parameter longint unsigned  STEP  = 215
) (
    input  logic [ACC_W-1:0] phase_i,
    output logic [ACC_W-1:0] phase_o
);
    localparam logic [ACC_W-1:0] INC = ACC_W'(STEP);

    always_comb begin
        phase_o = phase_i + INC;
    end
endmodule

// File: rtl/phacc_reg.sv
// Phase register, two-process form with synchronous clear.
module phacc_reg #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] next_i,
    output logic [ACC_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.phase = next_i;
        if (rst) begin
            state_d.phase = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign phase_o = state_q.phase;
endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
    parameter int unsigned     ACC_W = 32,
    parameter longint unsigned STEP  = 215
) (
    input  logic clk,
    input  logic rst,
    output logic led_o
);
    import led_blink_pkg::*;

    localparam int unsigned MSB = ACC_W - 1;

    if (!step_is_legal(ACC_W, STEP)) begin : g_bad_step
        $error("led_blink_div: STEP must be nonzero and below half the phase range (R8)");
    end

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;

    phacc_step #(
        .ACC_W (ACC_W),
        .STEP  (STEP)
    ) u_step (
        .phase_i (acc_q),
        .phase_o (acc_next)
    );

    phacc_reg #(
        .ACC_W (ACC_W)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .next_i  (acc_next),
        .phase_o (acc_q)
    );

    // Output is the registered top bit, with no logic after the flop.
    assign led_o = acc_q[MSB];
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
    parameter int unsigned     ACC_W = 32,
    parameter longint unsigned STEP  = 215
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] acc,
    input logic             led
);
    localparam longint unsigned  RANGE = 64'd1 << ACC_W;
    localparam longint unsigned  HALF  = 64'd1 << (ACC_W - 1);
    localparam longint unsigned  P_LO  = RANGE / STEP;
    localparam longint unsigned  P_HI  = (RANGE + STEP - 1) / STEP;
    localparam logic [ACC_W-1:0] INC   = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] HALFV = ACC_W'(HALF);

    logic        led_prev_q;
    logic        seen_q;
    logic [63:0] gap_q;
    logic        rise;

    assign rise = led && !led_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_prev_q <= 1'b0;
            seen_q     <= 1'b0;
            gap_q      <= 64'd0;
        end else begin
            led_prev_q <= led;
            if (rise) begin
                seen_q <= 1'b1;
                gap_q  <= 64'd1;
            end else if (gap_q != {64{1'b1}}) begin
                gap_q  <= gap_q + 64'd1;
            end
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (acc == '0) && !led);

    assert_step_add_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc == $past(acc) + INC);

    assert_msb_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(led) |-> (acc >= HALFV) && ((acc - HALFV) < INC));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(led) |-> acc < INC);

    assert_period_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_q && rise) |-> (gap_q >= P_LO) && (gap_q <= P_HI));
endmodule

bind led_blink_div led_blink_chk #(
    .ACC_W (ACC_W),
    .STEP  (STEP)
) u_chk (
    .clk (clk),
    .rst (rst),
    .acc (acc_q),
    .led (led_o)
);

// File: tb/led_blink_div_tb.sv
module led_blink_div_tb;
    localparam int unsigned     WA = 10;
    localparam longint unsigned PA = 37;
    localparam int unsigned     WB = 8;
    localparam longint unsigned PB = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic led_a, led_b;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    led_blink_div #(.ACC_W(WA), .STEP(PA)) u_dut (
        .clk (clk), .rst (rst), .led_o (led_a));
    led_blink_div #(.ACC_W(WB), .STEP(PB)) u_dut_b (
        .clk (clk), .rst (rst), .led_o (led_b));

    function automatic logic model(input longint unsigned k,
                                   input int unsigned w,
                                   input longint unsigned p);
        longint unsigned ph;
        ph = (k * p) % (64'd1 << w);
        return ph >= (64'd1 << (w - 1));
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-instance period tracking
    longint unsigned k;
    longint unsigned last_a, first_a, rises_a;
    longint unsigned last_b, first_b, rises_b;
    logic prev_a, prev_b;

    task automatic clear_track();
        k = 0; rises_a = 0; rises_b = 0;
        prev_a = 1'b0; prev_b = 1'b0;
        last_a = 0; first_a = 0; last_b = 0; first_b = 0;
    endtask

    task automatic period_check(input logic cur, inout logic prev,
                                inout longint unsigned last,
                                inout longint unsigned first,
                                inout longint unsigned rises,
                                input int unsigned w, input longint unsigned p,
                                input string tag);
        longint unsigned lo, hi, gap;
        lo = (64'd1 << w) / p;
        hi = ((64'd1 << w) + p - 1) / p;
        if (cur && !prev) begin
            if (rises > 0) begin
                gap = k - last;
                vectors++;
                if (gap < lo || gap > hi) begin
                    fails++;
                    $display("FAIL R5 %s: period %0d expected %0d..%0d", tag, gap, lo, hi);
                end
            end else begin
                first = k;
            end
            last = k;
            rises++;
        end
        prev = cur;
    endtask

    task automatic mean_check(input longint unsigned first, input longint unsigned last,
                              input longint unsigned rises, input int unsigned w,
                              input longint unsigned p, input string tag);
        longint signed diff, tol;
        vectors++;
        if (rises < 3) begin
            fails++;
            $display("FAIL R6 %s: only %0d rises, expected at least 3", tag, rises);
        end else begin
            diff = longint'((last - first) * p) - longint'((rises - 1) * (64'd1 << w));
            tol  = longint'((rises - 1) * p);
            if (diff > tol || -diff > tol) begin
                fails++;
                $display("FAIL R6 %s: span %0d over %0d periods, expected mean %0d/%0d",
                         tag, last - first, rises - 1, 64'd1 << w, p);
            end
        end
    endtask

    task automatic run(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            check(req, led_a, model(k, WA, PA));
            check(req, led_b, model(k, WB, PB));
            period_check(led_a, prev_a, last_a, first_a, rises_a, WA, PA, "A");
            period_check(led_b, prev_b, last_b, first_b, rises_b, WB, PB, "B");
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        clear_track();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", led_a, 1'b0);
        check("R1", led_b, 1'b0);
        rst = 1'b0;
        // R2/R3/R4: per-cycle model over two full phase cycles of config A
        run(2048, "R2_R3_R4");
        mean_check(first_a, last_a, rises_a, WA, PA, "A");
        mean_check(first_b, last_b, rises_b, WB, PB, "B");
        // R7: mid-run reset restarts from phase zero
        run(13, "R2");
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1_R7", led_a, 1'b0);
            check("R1_R7", led_b, 1'b0);
        end
        clear_track();
        rst = 1'b0;
        run(14, "R7");   // A low for ceil(512/37)-1 = 13 cycles, high on 14th
        check("R7", led_a, 1'b1);
        run(600, "R7");
        mean_check(first_a, last_a, rises_a, WA, PA, "A after reset");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule